// File: doc/BRIEF.md
# Parametric Set-Associative Cache Array

This block is the storage and lookup core of a level-one cache. It has a fixed line size of 32 bytes, a 32-bit address, and a set count and way count fixed at compile time. Each address is split into a byte offset, a set index and a tag. The tags of every way in the indexed set are compared in parallel, in the same cycle. The block reports whether the lookup hit and which way matched. It returns the whole matching line and the 32-bit word that the offset selects. Refill logic outside the block writes a complete line into one way of a set, and that way becomes valid.

Replacement order is kept per set by a recency unit that holds a rank for every way. The ranks of a set are always a permutation of 0 to WAYS-1, where rank 0 is the most recently used way. The way ranked WAYS-1 in the set addressed by the lookup port is shown on a victim output. Refill logic reads that output after a miss and sends the line to that way. With the default geometry of 128 sets and 2 ways, the array holds 8 KB. In general the capacity is sets × ways × 32 bytes. Both parameters must be powers of two and at least 2.

Top module: `setassoc_cache`

## Requirements
- R1: Address bits [4:0] are the byte offset and the next log2(SETS) bits are the set index. The remaining upper bits are the tag. A lookup matches a way of the indexed set when that way is valid and its stored tag equals the tag, and the result appears in the same cycle as the address.
- R2: `hit` is 1 only while `lookupEn` is 1 and some way matches. After reset every way of every set is invalid, so every lookup misses.
- R3: On a hit, `hitWay` is the binary number of the matching way and `rdLine` is its line. `rdWord` is the 32-bit word numbered by address bits [4:2], where word i sits in line bits [32i+31:32i].
- R4: When `fillEn` is 1, the line, the tag and the valid bit are written at the clock edge into way `fillWay` of the set addressed by `fillAddr`. A lookup in the same cycle sees the old contents, and a lookup in the next cycle hits. Fill logic never places a tag that is already present in the set.
- R5: After reset, way j of every set has rank j. `victimWay` is the way ranked WAYS-1 in the set addressed by `lookupAddr`.
- R6: An access to way k raises by one the rank of every way in that set whose rank is below k's rank, and sets k's rank to 0. Other sets are unchanged.
- R7: A fill is an access to its way, and a hit with `lookupEn` high is an access to the hitting way. If a fill and a hit happen in the same cycle, only the fill updates ranks. A lookup with `lookupEn` low updates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupEn | input | 1 | Qualifies a lookup |
| lookupAddr | input | 32 | Lookup byte address; also selects the set shown on victimWay |
| fillEn | input | 1 | Writes a line this cycle |
| fillAddr | input | 32 | Fill byte address (tag and set) |
| fillWay | input | log2(WAYS) | Destination way of the fill |
| fillLine | input | 256 | Line data to write |
| hit | output | 1 | Lookup matched a valid way |
| hitWay | output | log2(WAYS) | Number of the matching way |
| rdLine | output | 256 | Line of the matching way |
| rdWord | output | 32 | Word of the line chosen by address bits [4:2] |
| victimWay | output | log2(WAYS) | Least recently used way of the lookup set |

## Verification
The hardest state to reach is one where a set holds a different rank permutation after every access. Every way of a set has to be filled and then re-touched in an order that forces the least recently used way to move. This is needed to tell a full rank update apart from a simpler MRU scheme. The table fills all four ways of one set in victim order, touches them in a shuffled order, and then refills the way that has become least recent. It also checks that the evicted tag now misses. Directed steps then drive a fill and a hit into different sets in one cycle, and a disabled lookup that matches. In both cases the victim output reveals whether ranks moved that should have stayed.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int ADDR_W    = 32;
  localparam int OFF_W     = 5;
  localparam int WORD_W    = 32;
  localparam int LINE_BITS = 8 * (1 << OFF_W);

  typedef struct packed {
    logic fillWr;     // write tag, data and valid this cycle
    logic lookupArm;  // lookup qualified
  } cacheStrobes_t;
endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cacheStrobes_t                 ctrl,
  input  logic [ADDR_W-1:0]             lookupAddr,
  input  logic [ADDR_W-1:0]             fillAddr,
  input  logic [$clog2(WAYS)-1:0]       fillWay,
  input  logic [LINE_BITS-1:0]          fillLine,
  output logic                          hit,
  output logic [$clog2(WAYS)-1:0]       hitWay,
  output logic [LINE_BITS-1:0]          rdLine,
  output logic [WORD_W-1:0]             rdWord
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WSEL_W = OFF_W - 2;

  logic [TAG_W-1:0]     tagMem   [SETS][WAYS];
  logic [LINE_BITS-1:0] dataMem  [SETS][WAYS];
  logic [WAYS-1:0]      validMem [SETS];

  logic [IDX_W-1:0]  lkIdx, flIdx;
  logic [TAG_W-1:0]  lkTag, flTag;
  logic [WSEL_W-1:0] wordSel;
  logic [WAYS-1:0]   wayMatch;
  logic [WAY_W-1:0]  wayNum;
  logic [LINE_BITS-1:0] lineSel;
  logic [6:0] unusedAddrBits;

  assign lkIdx   = lookupAddr[OFF_W +: IDX_W];
  assign lkTag   = lookupAddr[ADDR_W-1 -: TAG_W];
  assign flIdx   = fillAddr[OFF_W +: IDX_W];
  assign flTag   = fillAddr[ADDR_W-1 -: TAG_W];
  assign wordSel = lookupAddr[OFF_W-1:2];
  assign unusedAddrBits = {lookupAddr[1:0], fillAddr[OFF_W-1:0]};

  // parallel compare, one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayMatch[w] = validMem[lkIdx][w] && (tagMem[lkIdx][w] == lkTag);
  end

  // one-hot match to way number and line mux
  always_comb begin
    wayNum  = '0;
    lineSel = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayMatch[w]) begin
        wayNum  = wayNum | WAY_W'(w);
        lineSel = lineSel | dataMem[lkIdx][w];
      end
    end
  end

  assign hit    = ctrl.lookupArm && (|wayMatch);
  assign hitWay = wayNum;
  assign rdLine = lineSel;
  assign rdWord = lineSel[WORD_W*wordSel +: WORD_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (ctrl.fillWr) begin
      validMem[flIdx][fillWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.fillWr) begin
      tagMem[flIdx][fillWay]  <= flTag;
      dataMem[flIdx][fillWay] <= fillLine;
    end
  end
endmodule

// File: rtl/cache_recency.sv
module cache_recency
  import cache_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lookupEn,
  input  logic [$clog2(SETS)-1:0]  lookupIdx,
  input  logic                     hit,
  input  logic [$clog2(WAYS)-1:0]  hitWay,
  input  logic                     fillEn,
  input  logic [$clog2(SETS)-1:0]  fillIdx,
  input  logic [$clog2(WAYS)-1:0]  fillWay,
  output cacheStrobes_t            ctrl,
  output logic [$clog2(WAYS)-1:0]  victimWay
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] rankMem [SETS][WAYS];

  logic             touchEn;
  logic [IDX_W-1:0] tIdx;
  logic [WAY_W-1:0] tWay;
  logic [WAY_W-1:0] tRank;

  always_comb begin
    ctrl.fillWr    = fillEn;
    ctrl.lookupArm = lookupEn;
  end

  // fill has priority over a same-cycle hit
  assign touchEn = fillEn || hit;
  assign tIdx    = fillEn ? fillIdx : lookupIdx;
  assign tWay    = fillEn ? fillWay : hitWay;
  assign tRank   = rankMem[tIdx][tWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rankMem[s][w] <= WAY_W'(w);
    end else if (touchEn) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == tWay)
          rankMem[tIdx][w] <= '0;
        else if (rankMem[tIdx][w] < tRank)
          rankMem[tIdx][w] <= rankMem[tIdx][w] + WAY_W'(1);
      end
    end
  end

  always_comb begin
    victimWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (rankMem[lookupIdx][w] == WAY_W'(WAYS-1)) victimWay = WAY_W'(w);
  end
endmodule

// File: rtl/setassoc_cache.sv
module setassoc_cache
  import cache_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lookupEn,
  input  logic [31:0]              lookupAddr,
  input  logic                     fillEn,
  input  logic [31:0]              fillAddr,
  input  logic [$clog2(WAYS)-1:0]  fillWay,
  input  logic [255:0]             fillLine,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hitWay,
  output logic [255:0]             rdLine,
  output logic [31:0]              rdWord,
  output logic [$clog2(WAYS)-1:0]  victimWay
);
  localparam int IDX_W = $clog2(SETS);

  cacheStrobes_t ctrl;

  cache_recency #(.SETS(SETS), .WAYS(WAYS)) u_recency (
    .clk       (clk),
    .rstN      (rstN),
    .lookupEn  (lookupEn),
    .lookupIdx (lookupAddr[OFF_W +: IDX_W]),
    .hit       (hit),
    .hitWay    (hitWay),
    .fillEn    (fillEn),
    .fillIdx   (fillAddr[OFF_W +: IDX_W]),
    .fillWay   (fillWay),
    .ctrl      (ctrl),
    .victimWay (victimWay)
  );

  cache_datapath #(.SETS(SETS), .WAYS(WAYS)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .lookupAddr (lookupAddr),
    .fillAddr   (fillAddr),
    .fillWay    (fillWay),
    .fillLine   (fillLine),
    .hit        (hit),
    .hitWay     (hitWay),
    .rdLine     (rdLine),
    .rdWord     (rdWord)
  );
endmodule

// File: rtl/setassoc_cache_checker.sv
module setassoc_cache_checker #(
  parameter int SETS = 128,
  parameter int WAYS = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     lookupEn,
  input logic [26:0]              lkLineAddr,
  input logic                     fillEn,
  input logic [26:0]              flLineAddr,
  input logic [$clog2(WAYS)-1:0]  fillWay,
  input logic                     hit,
  input logic [$clog2(WAYS)-1:0]  hitWay,
  input logic [$clog2(WAYS)-1:0]  victimWay
);
  localparam int IDX_W = $clog2(SETS);

  logic seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> lookupEn); // R2

  AST_FILL_SEEN_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(fillEn) && lookupEn && (lkLineAddr == $past(flLineAddr)))
      |-> (hit && (hitWay == $past(fillWay)))); // R4

  AST_FILLED_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(fillEn) && (lkLineAddr[IDX_W-1:0] == $past(flLineAddr[IDX_W-1:0])))
      |-> (victimWay != $past(fillWay))); // R6

  AST_HIT_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(lookupEn && hit && !fillEn)
          && (lkLineAddr[IDX_W-1:0] == $past(lkLineAddr[IDX_W-1:0])))
      |-> (victimWay != $past(hitWay))); // R7
endmodule

bind setassoc_cache setassoc_cache_checker #(.SETS(SETS), .WAYS(WAYS)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .lookupEn   (lookupEn),
  .lkLineAddr (lookupAddr[31:5]),
  .fillEn     (fillEn),
  .flLineAddr (fillAddr[31:5]),
  .fillWay    (fillWay),
  .hit        (hit),
  .hitWay     (hitWay),
  .victimWay  (victimWay)
);

// File: tb/setassoc_cache_bench.sv
module setassoc_cache_bench;
  localparam int BS = 16;
  localparam int BW = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         lookupEn = 1'b0;
  logic [31:0]  lookupAddr = '0;
  logic         fillEn = 1'b0;
  logic [31:0]  fillAddr = '0;
  logic [1:0]   fillWay = '0;
  logic [255:0] fillLine = '0;
  logic         hit;
  logic [1:0]   hitWay;
  logic [255:0] rdLine;
  logic [31:0]  rdWord;
  logic [1:0]   victimWay;

  always #4 clk = ~clk; // 125 MHz

  setassoc_cache #(.SETS(BS), .WAYS(BW)) u_setassoc_cache (
    .clk(clk), .rstN(rstN), .lookupEn(lookupEn), .lookupAddr(lookupAddr),
    .fillEn(fillEn), .fillAddr(fillAddr), .fillWay(fillWay), .fillLine(fillLine),
    .hit(hit), .hitWay(hitWay), .rdLine(rdLine), .rdWord(rdWord), .victimWay(victimWay)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model built from the requirements
  logic [22:0]  mTag   [BS][BW];
  logic         mValid [BS][BW];
  logic [255:0] mData  [BS][BW];
  int           mRank  [BS][BW];

  function automatic void modelReset();
    for (int s = 0; s < BS; s++)
      for (int w = 0; w < BW; w++) begin
        mValid[s][w] = 1'b0;
        mRank[s][w]  = w;
      end
  endfunction

  function automatic int modelVictim(int s);
    for (int w = 0; w < BW; w++) if (mRank[s][w] == BW-1) return w;
    return 0;
  endfunction

  function automatic void modelTouch(int s, int k);
    int r = mRank[s][k];
    for (int w = 0; w < BW; w++) begin
      if (w == k) mRank[s][w] = 0;
      else if (mRank[s][w] < r) mRank[s][w] = mRank[s][w] + 1;
    end
  endfunction

  function automatic logic [31:0] mkAddr(logic [22:0] tag, logic [3:0] set, logic [2:0] word);
    return {tag, set, word, 2'b00};
  endfunction

  function automatic logic [255:0] mkLine(logic [7:0] seed);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[32*i +: 32] = {seed, 8'h5A, seed ^ 8'hC3, 8'(i)};
    return l;
  endfunction

  task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 2 ns later, edge commits
  task automatic step(string req, logic le, logic [31:0] la, logic fe, logic [31:0] fa,
                      logic [1:0] fw, logic [255:0] fl, output logic gotHit, output logic [1:0] gotVic);
    int s, fs, mWay;
    logic mHit, expH;
    @(negedge clk);
    lookupEn = le; lookupAddr = la; fillEn = fe; fillAddr = fa; fillWay = fw; fillLine = fl;
    #2;
    s = int'(la[8:5]);
    mHit = 1'b0; mWay = 0;
    for (int w = 0; w < BW; w++)
      if (mValid[s][w] && mTag[s][w] == la[31:9]) begin mHit = 1'b1; mWay = w; end
    expH = le & mHit;
    check(req, "hit", 256'(hit), 256'(expH));
    if (expH) begin // R3 way number, line and selected word
      check("R3", "hitWay", 256'(hitWay), 256'(mWay));
      check("R3", "rdLine", rdLine, mData[s][mWay]);
      check("R3", "rdWord", 256'(rdWord), 256'(mData[s][mWay][32*la[4:2] +: 32]));
    end
    check("R5", "victimWay", 256'(victimWay), 256'(modelVictim(s)));
    gotHit = hit; gotVic = victimWay;
    if (fe) begin
      fs = int'(fa[8:5]);
      mTag[fs][fw] = fa[31:9]; mValid[fs][fw] = 1'b1; mData[fs][fw] = fl;
      modelTouch(fs, int'(fw));
    end else if (expH) begin
      modelTouch(s, mWay);
    end
    @(posedge clk);
  endtask

  typedef struct packed {
    logic        isFill;
    logic [22:0] tag;
    logic [3:0]  set;
    logic [2:0]  word;
    logic [1:0]  way;
    logic        expHit;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{1'b0, 23'd1, 4'd3, 3'd0, 2'd0, 1'b0, 8'd0},
    '{1'b1, 23'd1, 4'd3, 3'd0, 2'd3, 1'b0, 8'd11},
    '{1'b0, 23'd1, 4'd3, 3'd5, 2'd0, 1'b1, 8'd0},
    '{1'b1, 23'd2, 4'd3, 3'd0, 2'd2, 1'b0, 8'd22},
    '{1'b1, 23'd3, 4'd3, 3'd0, 2'd1, 1'b0, 8'd33},
    '{1'b1, 23'd4, 4'd3, 3'd0, 2'd0, 1'b0, 8'd44},
    '{1'b0, 23'd2, 4'd3, 3'd7, 2'd0, 1'b1, 8'd0},
    '{1'b0, 23'd3, 4'd3, 3'd2, 2'd0, 1'b1, 8'd0},
    '{1'b0, 23'd4, 4'd3, 3'd1, 2'd0, 1'b1, 8'd0},
    '{1'b0, 23'd5, 4'd3, 3'd0, 2'd0, 1'b0, 8'd0},
    '{1'b0, 23'd1, 4'd3, 3'd3, 2'd0, 1'b1, 8'd0},
    '{1'b0, 23'd1, 4'd4, 3'd0, 2'd0, 1'b0, 8'd0},
    '{1'b1, 23'd5, 4'd3, 3'd0, 2'd2, 1'b0, 8'd55},
    '{1'b0, 23'd2, 4'd3, 3'd0, 2'd0, 1'b0, 8'd0},
    '{1'b0, 23'd5, 4'd3, 3'd6, 2'd0, 1'b1, 8'd0},
    '{1'b1, 23'd1, 4'd4, 3'd0, 2'd3, 1'b0, 8'd66}
  };

  initial begin
    #(8 * 50000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic h;
    logic [1:0] vc;
    logic [31:0] a5;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // table: R1 split and compare, R4 fills into the victim, R6 rank order
    for (int i = 0; i < 16; i++) begin
      vec_t v = VEC[i];
      logic [31:0] a = mkAddr(v.tag, v.set, v.word);
      if (v.isFill) begin
        step("R4", 1'b0, a, 1'b1, a, v.way, mkLine(v.seed), h, vc);
        check("R6", "table victim before fill", 256'(vc), 256'(v.way));
      end else begin
        step("R1", 1'b1, a, 1'b0, '0, '0, '0, h, vc);
        check("R1", "table hit", 256'(h), 256'(v.expHit));
      end
    end

    // R2 / R5: reset clears valid bits and restores ranks
    @(negedge clk); rstN = 1'b0; lookupEn = 1'b0; fillEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1; modelReset();
    step("R2", 1'b1, mkAddr(23'd1, 4'd3, 3'd0), 1'b0, '0, '0, '0, h, vc);
    check("R2", "miss after reset", 256'(h), 256'(0));
    check("R5", "victim after reset", 256'(vc), 256'(3));
    step("R2", 1'b1, mkAddr(23'd0, 4'd0, 3'd0), 1'b0, '0, '0, '0, h, vc);
    check("R2", "miss on zero tag after reset", 256'(h), 256'(0));

    // R4: same-cycle fill and lookup sees old contents, next cycle hits
    a5 = mkAddr(23'd77, 4'd5, 3'd2);
    step("R4", 1'b1, a5, 1'b1, a5, 2'd3, mkLine(8'd90), h, vc);
    check("R4", "same-cycle lookup sees old", 256'(h), 256'(0));
    step("R4", 1'b1, a5, 1'b0, '0, '0, '0, h, vc);
    check("R4", "hit after fill", 256'(h), 256'(1));

    // fill the other ways of set 5 so tag 77 becomes least recent
    step("R7", 1'b0, a5, 1'b1, mkAddr(23'd78, 4'd5, 3'd0), 2'd2, mkLine(8'd91), h, vc);
    step("R7", 1'b0, a5, 1'b1, mkAddr(23'd79, 4'd5, 3'd0), 2'd1, mkLine(8'd92), h, vc);
    step("R7", 1'b0, a5, 1'b1, mkAddr(23'd80, 4'd5, 3'd0), 2'd0, mkLine(8'd93), h, vc);
    step("R7", 1'b0, a5, 1'b0, '0, '0, '0, h, vc);
    check("R7", "fills ranked way3 last", 256'(vc), 256'(3));

    // R7: matching lookup with enable low changes nothing
    step("R7", 1'b0, a5, 1'b0, '0, '0, '0, h, vc);
    check("R2", "disabled lookup no hit", 256'(h), 256'(0));
    step("R7", 1'b0, a5, 1'b0, '0, '0, '0, h, vc);
    check("R7", "disabled lookup no rank change", 256'(vc), 256'(3));

    // R7: fill in set 6 and hit in set 5 together, only the fill counts
    step("R7", 1'b1, a5, 1'b1, mkAddr(23'd81, 4'd6, 3'd0), 2'd3, mkLine(8'd94), h, vc);
    check("R7", "hit reported during fill", 256'(h), 256'(1));
    step("R7", 1'b0, a5, 1'b0, '0, '0, '0, h, vc);
    check("R7", "fill priority kept set 5 ranks", 256'(vc), 256'(3));

    // R6: a real hit on the least recent way promotes it
    step("R6", 1'b1, a5, 1'b0, '0, '0, '0, h, vc);
    step("R6", 1'b0, a5, 1'b0, '0, '0, '0, h, vc);
    check("R6", "hit moved victim", 256'(vc), 256'(2));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule